// File: doc/BRIEF.md
# Multi-Rate Enable Generator for a Two-Stage Decimator

This block paces a two-stage decimation chain in which every stage runs on one system clock and moves forward only on clock-enable strobes. It takes one master enable and produces a set of slower strobes, all phase-locked to it. The first filter runs at the master rate. The first filter needs `FOLD_P` master enables to compute each output sample. The first stage keeps one sample in `DEC1_P`. The second stage keeps one sample in `DEC2_P`.

Every rate has its own wrap-around phase counter. A counter moves forward only on cycles where the master enable is high. Each strobe is the master enable ANDed with a match on a chosen counter phase. That phase is either the first phase (count 0) or the last phase (count N−1). The counter for the final output rate steps once each time the inter-stage counter wraps. The output strobe is therefore a sub-sample of the inter-stage first-phase strobe.

With the defaults (4, 9, 4), the periods are 1, 4, 9, 36 and 144 master enables. A 400 kHz master enable therefore gives a final rate of 100 ksps/36.

Top module: `mre_enable_gen`

## Requirements
- R1: `en_fir1_o` equals `clk_en_i` in every cycle.
- R2: No strobe is high in a cycle where `clk_en_i` is low. Cycles with the enable low do not move any counter, so gaps in the enable never shift a strobe's phase.
- R3: Enabled cycles are numbered k = 0, 1, 2, … from the first enabled cycle after reset. `en_s1_out_o` is high exactly on enabled cycles with k mod FOLD_P = FOLD_P−1 (last phase, period FOLD_P).
- R4: `en_fir2_o` is high exactly on enabled cycles with k mod DEC1_P = 0 (first phase, period DEC1_P).
- R5: `en_link_first_o` is high exactly on enabled cycles with k mod (FOLD_P·DEC1_P) = 0. `en_link_last_o` is high exactly on enabled cycles with k mod (FOLD_P·DEC1_P) = FOLD_P·DEC1_P−1.
- R6: `en_out_o` is high exactly on enabled cycles with k mod (FOLD_P·DEC1_P·DEC2_P) = 0. With the defaults this is one pulse per 144 master enables.
- R7: While `rst_ni` is low with the enable low, all strobes are low. On the first enabled cycle after reset is released, `en_fir2_o`, `en_link_first_o` and `en_out_o` are all high.
- R8: Asserting `rst_ni` in the middle of a run sets every counter back to phase 0 at once. After release, numbering restarts at k = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Master clock enable |
| en_fir1_o | output | 1 | First-filter enable, same as master enable |
| en_s1_out_o | output | 1 | First-filter output strobe, period FOLD_P, last phase |
| en_fir2_o | output | 1 | Second-filter enable, period DEC1_P, first phase |
| en_link_last_o | output | 1 | Inter-stage strobe, period FOLD_P·DEC1_P, last phase |
| en_link_first_o | output | 1 | Inter-stage strobe, period FOLD_P·DEC1_P, first phase |
| en_out_o | output | 1 | Final output strobe, period FOLD_P·DEC1_P·DEC2_P, first phase |

## Verification
Every strobe is combinational from the master enable and the registered counters. So a strobe is due in the same cycle as the enable that produces it, and counter movement first shows one clock edge later. The bench changes the enable on the falling edge and compares all six outputs 1 ns later. It advances its own count of enabled cycles only after the following rising edge, so each expected value comes from the count as it stood before that edge. The bench runs continuous, alternating, one-in-three, bursty and pseudo-random enable patterns long enough to pass through the 144-enable period several times. It also applies a reset in the middle of a run.

// File: rtl/mre_pkg.sv
package mre_pkg;
  typedef enum logic {PH_FIRST, PH_LAST} phase_e;

  localparam int FOLD_DEF = 4;
  localparam int DEC1_DEF = 9;
  localparam int DEC2_DEF = 4;

  function automatic int cnt_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mre_mod_cnt.sv
module mre_mod_cnt #(
  parameter int N = 4,
  localparam int W = mre_pkg::cnt_w(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         adv_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  generate
    if (N > 1) begin : g_count
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    cnt_o <= '0;
        else if (adv_i) cnt_o <= (cnt_o == LAST) ? '0 : cnt_o + 1'b1;
      end
    end else begin : g_const
      assign cnt_o = '0;
    end
  endgenerate
endmodule

// File: rtl/mre_phase_tap.sv
module mre_phase_tap #(
  parameter int              N     = 4,
  parameter mre_pkg::phase_e PHASE = mre_pkg::PH_FIRST,
  localparam int W = mre_pkg::cnt_w(N)
) (
  input  logic         adv_i,
  input  logic [W-1:0] cnt_i,
  output logic         stb_o
);
  generate
    if (PHASE == mre_pkg::PH_LAST) begin : g_last
      assign stb_o = adv_i && (cnt_i == W'(N - 1));
    end else begin : g_first
      assign stb_o = adv_i && (cnt_i == '0);
    end
  endgenerate
endmodule

// File: rtl/mre_enable_gen.sv
module mre_enable_gen #(
  parameter int FOLD_P = mre_pkg::FOLD_DEF,
  parameter int DEC1_P = mre_pkg::DEC1_DEF,
  parameter int DEC2_P = mre_pkg::DEC2_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clk_en_i,
  output logic en_fir1_o,
  output logic en_s1_out_o,
  output logic en_fir2_o,
  output logic en_link_last_o,
  output logic en_link_first_o,
  output logic en_out_o
);
  import mre_pkg::*;

  localparam int LINK_N = FOLD_P * DEC1_P;
  localparam int W_FOLD = cnt_w(FOLD_P);
  localparam int W_DEC1 = cnt_w(DEC1_P);
  localparam int W_LINK = cnt_w(LINK_N);
  localparam int W_DEC2 = cnt_w(DEC2_P);

  logic [W_FOLD-1:0] fold_cnt;
  logic [W_DEC1-1:0] dec1_cnt;
  logic [W_LINK-1:0] link_cnt;
  logic [W_DEC2-1:0] out_cnt;

  assign en_fir1_o = clk_en_i;

  mre_mod_cnt #(.N(FOLD_P)) u_fold_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(clk_en_i), .cnt_o(fold_cnt));
  mre_mod_cnt #(.N(DEC1_P)) u_dec1_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(clk_en_i), .cnt_o(dec1_cnt));
  mre_mod_cnt #(.N(LINK_N)) u_link_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(clk_en_i), .cnt_o(link_cnt));
  // final-rate counter steps once per inter-stage wrap
  mre_mod_cnt #(.N(DEC2_P)) u_out_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(en_link_last_o), .cnt_o(out_cnt));

  mre_phase_tap #(.N(FOLD_P), .PHASE(PH_LAST)) u_tap_s1 (
    .adv_i(clk_en_i), .cnt_i(fold_cnt), .stb_o(en_s1_out_o));
  mre_phase_tap #(.N(DEC1_P), .PHASE(PH_FIRST)) u_tap_fir2 (
    .adv_i(clk_en_i), .cnt_i(dec1_cnt), .stb_o(en_fir2_o));
  mre_phase_tap #(.N(LINK_N), .PHASE(PH_LAST)) u_tap_link_last (
    .adv_i(clk_en_i), .cnt_i(link_cnt), .stb_o(en_link_last_o));
  mre_phase_tap #(.N(LINK_N), .PHASE(PH_FIRST)) u_tap_link_first (
    .adv_i(clk_en_i), .cnt_i(link_cnt), .stb_o(en_link_first_o));
  mre_phase_tap #(.N(DEC2_P), .PHASE(PH_FIRST)) u_tap_out (
    .adv_i(en_link_first_o), .cnt_i(out_cnt), .stb_o(en_out_o));
endmodule

// File: rtl/mre_enable_gen_chk.sv
module mre_enable_gen_chk #(
  parameter int FOLD_P = 4,
  parameter int DEC1_P = 9,
  parameter int DEC2_P = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic clk_en_i,
  input logic en_fir1_o,
  input logic en_s1_out_o,
  input logic en_fir2_o,
  input logic en_link_last_o,
  input logic en_link_first_o,
  input logic en_out_o
);
  localparam int LINK_N = FOLD_P * DEC1_P;
  localparam int TOT_N  = LINK_N * DEC2_P;

  int k;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       k <= 0;
    else if (clk_en_i) k <= (k == TOT_N - 1) ? 0 : k + 1;
  end

  a_r1_fir1_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fir1_o == clk_en_i);
  a_r2_quiet_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |-> !(en_s1_out_o || en_fir2_o || en_link_last_o || en_link_first_o || en_out_o));
  a_r3_s1_last_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s1_out_o == (clk_en_i && ((k % FOLD_P) == FOLD_P - 1)));
  a_r4_fir2_first_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_fir2_o == (clk_en_i && ((k % DEC1_P) == 0)));
  a_r5_link_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_link_first_o == (clk_en_i && ((k % LINK_N) == 0)));
  a_r5_link_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_link_last_o == (clk_en_i && ((k % LINK_N) == LINK_N - 1)));
  a_r5_link_nests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_link_first_o |-> en_fir2_o) and (en_link_last_o |-> en_s1_out_o));
  a_r6_out_first_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_out_o == (clk_en_i && (k == 0)));
  a_r6_out_nests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_out_o |-> en_link_first_o);
endmodule

bind mre_enable_gen mre_enable_gen_chk #(
  .FOLD_P(FOLD_P), .DEC1_P(DEC1_P), .DEC2_P(DEC2_P)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i),
  .en_fir1_o(en_fir1_o), .en_s1_out_o(en_s1_out_o), .en_fir2_o(en_fir2_o),
  .en_link_last_o(en_link_last_o), .en_link_first_o(en_link_first_o),
  .en_out_o(en_out_o)
);

// File: tb/mre_enable_gen_bench.sv
`timescale 1ns/1ps
module mre_enable_gen_bench;
  localparam int FOLD = 4, DEC1 = 9, DEC2 = 4;
  localparam int LINK = FOLD * DEC1;
  localparam int TOT  = LINK * DEC2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic fir1, s1, fir2, ll, lf, outs;

  int checks = 0, fails = 0, idx = 0;
  bit done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  mre_enable_gen #(.FOLD_P(FOLD), .DEC1_P(DEC1), .DEC2_P(DEC2)) u_mre_enable_gen (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en),
    .en_fir1_o(fir1), .en_s1_out_o(s1), .en_fir2_o(fir2),
    .en_link_last_o(ll), .en_link_first_o(lf), .en_out_o(outs));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s k=%0d actual=%b expected=%b", req, what, idx, act, exp);
    end
  endtask

  // compare all strobes against the arithmetic model for current idx/en
  task automatic chk_all();
    string rq;
    chk("R1", "fir1", fir1, en);
    rq = en ? "R3" : "R2";
    chk(rq, "s1_out", s1, en && (idx % FOLD == FOLD - 1));
    rq = en ? "R4" : "R2";
    chk(rq, "fir2", fir2, en && (idx % DEC1 == 0));
    rq = en ? "R5" : "R2";
    chk(rq, "link_first", lf, en && (idx % LINK == 0));
    chk(rq, "link_last", ll, en && (idx % LINK == LINK - 1));
    rq = en ? "R6" : "R2";
    chk(rq, "out", outs, en && (idx % TOT == 0));
  endtask

  function automatic logic pat(input int mode, input int c, input logic [15:0] r);
    case (mode)
      0: return 1'b1;
      1: return c[0];
      2: return (c % 3) == 0;
      3: return r[0] ^ r[5];
      default: return (c % 27) >= 20;
    endcase
  endfunction

  task automatic run(input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      en = pat(mode, c, lfsr);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      #1 chk_all();
      @(posedge clk);
      if (en) idx++;
    end
  endtask

  task automatic first_after_reset(input string req);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    #1;
    chk(req, "fir2 first", fir2, 1'b1);
    chk(req, "link_first first", lf, 1'b1);
    chk(req, "out first", outs, 1'b1);
    chk(req, "s1 quiet first", s1, 1'b0);
    @(posedge clk);
    idx = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R7", "reset fir1", fir1, 1'b0);
    chk("R7", "reset s1", s1, 1'b0);
    chk("R7", "reset fir2", fir2, 1'b0);
    chk("R7", "reset link_first", lf, 1'b0);
    chk("R7", "reset link_last", ll, 1'b0);
    chk("R7", "reset out", outs, 1'b0);
    idx = 0;
    first_after_reset("R7");
    run(0, 400);
    run(1, 400);
    run(2, 500);
    run(4, 600);
    run(3, 1500);
    // mid-run reset
    @(negedge clk);
    en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R8", "mid reset out", outs, 1'b0);
    chk("R8", "mid reset s1", s1, 1'b0);
    idx = 0;
    @(negedge clk);
    first_after_reset("R8");
    run(0, 300);
    run(3, 400);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule